// File: doc/BRIEF.md
# Encoder Parity Output FIFO

This block sits beside a Reed-Solomon encoder and holds the parity it produces at the end of each packet. When the encoder signals that parity is done, the block captures the whole parity block as five 16-bit words at once, raises a parity-ready flag and points its read pointer at word 0. Software then pulls the words out one at a time through a read strobe. Each read returns one word on a 16-bit read register.

Reads never stall. A read made while parity is ready returns the word at the pointer and moves the pointer on. After word 4 the pointer wraps to word 0. A read made while parity is not ready returns the word at the pointer and leaves the pointer where it is.

The ready flag is not cleared by reading. It is cleared when the encoder accepts the first data beat of the next packet. The block also gates the data path into the encoder: data beats pass through only while the encoder enable input is set.

Top module: `enc_par_fifo`

## Requirements
- R1: After reset, `rd_data_o` is 0000h, `par_rdy_o` is 0 and `enc_valid_o` is 0.
- R2: A cycle with `par_done_i` high stores all five words and sets `par_rdy_o` in the following cycle. Word k is `par_data_i[16k+15:16k]`. The same cycle resets the read pointer to word 0, whatever its previous position.
- R3: A beat with `data_valid_i`, `pkt_first_i` and `enc_en_i` all high clears `par_rdy_o` in the following cycle. If `par_done_i` is high in the same cycle, the set takes priority and the flag stays 1.
- R4: A read (`rd_en_i` high for one cycle) while `par_rdy_o` is 1 loads the word at the pointer into `rd_data_o` in the following cycle and advances the pointer. Words come out in order from word 0 to word 4.
- R5: The read after word 4 returns word 0, because the pointer wraps.
- R6: A read while `par_rdy_o` is 0 completes in one cycle with no wait indication. It returns the word at the pointer and does not advance the pointer. Reading never clears `par_rdy_o`.
- R7: A data beat is forwarded as `enc_valid_o`/`enc_data_o` one cycle later only while `enc_en_i` is 1. With `enc_en_i` at 0, `enc_valid_o` stays 0.
- R8: `rd_data_o` keeps its value in every cycle with no read.
- R9: A first-data beat while `enc_en_i` is 0 leaves `par_rdy_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_en_i | input | 1 | Encoder enable |
| data_valid_i | input | 1 | A data beat is transferred this cycle |
| data_i | input | 16 | Transferred data word |
| pkt_first_i | input | 1 | The current beat is the first of a packet |
| enc_valid_o | output | 1 | Data beat forwarded to the encoder input |
| enc_data_o | output | 16 | Forwarded data word |
| par_done_i | input | 1 | Parity computation finished, pulse |
| par_data_i | input | 80 | Five parity words, word k at bits 16k+15:16k |
| par_rdy_o | output | 1 | Parity ready to be read |
| rd_en_i | input | 1 | Read strobe, one word per cycle |
| rd_data_o | output | 16 | Read data register |

## Verification
On every cycle the assertions check four things:
- the flag follows its set and clear rules, including the set-over-clear priority;
- the pointer stays in range, wraps after the last word and holds on reads made while not ready;
- the read register stays stable when no read occurs;
- the forward path stays silent while the encoder is disabled.

Only the bench scenarios can show the data itself. These are the word order for each packet, the word returned after the wrap, a new parity block reloading storage and the pointer in the middle of a readout, and repeated not-ready reads returning the same word.

// File: rtl/enc_par_pkg.sv
package enc_par_pkg;
  localparam int unsigned WORD_W_DEF    = 16;
  localparam int unsigned NUM_WORDS_DEF = 5;
endpackage

// File: rtl/par_store.sv
module par_store #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned PTR_W    = $clog2(NUM_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [NUM_WORDS*WORD_W-1:0] load_data_i,
  input  logic [PTR_W-1:0]            sel_i,
  output logic [WORD_W-1:0]           word_o
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     words[g] <= '0;
      else if (load_i) words[g] <= load_data_i[g*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (sel_i == PTR_W'(i)) word_o = words[i];
  end
endmodule

// File: rtl/par_rd_ptr.sv
module par_rd_ptr #(
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned PTR_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= '0;        // new parity restarts readout
    else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/par_rdy_flag.sv
module par_rdy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic rdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdy_o <= 1'b0;
    else if (set_i)  rdy_o <= 1'b1;      // set wins over clear
    else if (clr_i)  rdy_o <= 1'b0;
  end
endmodule

// File: rtl/enc_in_gate.sv
module enc_in_gate #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i & en_i;
      if (valid_i & en_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/enc_par_fifo.sv
module enc_par_fifo
  import enc_par_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned NUM_WORDS = NUM_WORDS_DEF,
  localparam int unsigned PTR_W    = $clog2(NUM_WORDS),
  localparam int unsigned BLK_W    = NUM_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_en_i,
  input  logic              data_valid_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              pkt_first_i,
  output logic              enc_valid_o,
  output logic [WORD_W-1:0] enc_data_o,
  input  logic              par_done_i,
  input  logic [BLK_W-1:0]  par_data_i,
  output logic              par_rdy_o,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [PTR_W-1:0]  rd_ptr;
  logic [WORD_W-1:0] cur_word;
  logic              first_beat;

  assign first_beat = data_valid_i & pkt_first_i & enc_en_i;

  par_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk_i, .rst_ni,
    .load_i      (par_done_i),
    .load_data_i (par_data_i),
    .sel_i       (rd_ptr),
    .word_o      (cur_word)
  );

  par_rd_ptr #(.NUM_WORDS(NUM_WORDS)) u_ptr (
    .clk_i, .rst_ni,
    .load_i (par_done_i),
    .adv_i  (rd_en_i & par_rdy_o),
    .ptr_o  (rd_ptr)
  );

  par_rdy_flag u_rdy (
    .clk_i, .rst_ni,
    .set_i (par_done_i),
    .clr_i (first_beat),
    .rdy_o (par_rdy_o)
  );

  enc_in_gate #(.WORD_W(WORD_W)) u_gate (
    .clk_i, .rst_ni,
    .en_i    (enc_en_i),
    .valid_i (data_valid_i),
    .data_i  (data_i),
    .valid_o (enc_valid_o),
    .data_o  (enc_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= cur_word;
  end
endmodule

// File: rtl/enc_par_fifo_chk.sv
module enc_par_fifo_chk #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned PTR_W    = $clog2(NUM_WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enc_en_i,
  input logic              data_valid_i,
  input logic              pkt_first_i,
  input logic              enc_valid_o,
  input logic              par_done_i,
  input logic              par_rdy_o,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [PTR_W-1:0]  rd_ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS - 1);

  AST_RDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_done_i |=> par_rdy_o); // R2
  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_done_i |=> rd_ptr == '0); // R2
  AST_RDY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && pkt_first_i && enc_en_i && !par_done_i) |=> !par_rdy_o); // R3
  AST_RDY_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_rdy_o && !(data_valid_i && pkt_first_i && enc_en_i)) |=> par_rdy_o); // R9
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr <= LAST); // R4
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && par_rdy_o && rd_ptr == LAST && !par_done_i) |=> rd_ptr == '0); // R5
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !par_rdy_o && !par_done_i) |=> $stable(rd_ptr)); // R6
  AST_RD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R8
  AST_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_en_i |=> !enc_valid_o); // R7
endmodule

bind enc_par_fifo enc_par_fifo_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk_i, .rst_ni, .enc_en_i, .data_valid_i, .pkt_first_i, .enc_valid_o,
  .par_done_i, .par_rdy_o, .rd_en_i, .rd_data_o, .rd_ptr
);

// File: tb/enc_par_fifo_tb.sv
module enc_par_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int N = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enc_en_i = 1'b0, data_valid_i = 1'b0, pkt_first_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic enc_valid_o;
  logic [W-1:0] enc_data_o;
  logic par_done_i = 1'b0;
  logic [N*W-1:0] par_data_i = '0;
  logic par_rdy_o;
  logic rd_en_i = 1'b0;
  logic [W-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] mdl_words [N];
  int mdl_ptr = 0;
  bit mdl_rdy = 1'b0;
  logic [W-1:0] exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  enc_par_fifo u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: one read, expected word pushed into scoreboard
  task automatic do_read(input string tag);
    exp_q.push_back(mdl_words[mdl_ptr]);
    tag_q.push_back(tag);
    if (mdl_rdy) mdl_ptr = (mdl_ptr == N-1) ? 0 : mdl_ptr + 1;
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic load_parity(input int seed);
    for (int k = 0; k < N; k++) begin
      mdl_words[k] = W'(seed * 16'h0101 + k * 16'h1111 + 16'h0a05);
      par_data_i[k*W +: W] = mdl_words[k];
    end
    mdl_ptr = 0;
    mdl_rdy = 1'b1;
    par_done_i = 1'b1;
    @(negedge clk_i);
    par_done_i = 1'b0;
  endtask

  task automatic first_beat(input bit en);
    enc_en_i = en; data_valid_i = 1'b1; pkt_first_i = 1'b1; data_i = 16'h5a5a;
    if (en) mdl_rdy = 1'b0;
    @(negedge clk_i);
    data_valid_i = 1'b0; pkt_first_i = 1'b0;
  endtask

  // monitor: compares read results one cycle after each strobe
  initial begin
    forever begin
      bit p;
      @(posedge clk_i);
      p = rd_en_i;
      @(negedge clk_i);
      if (p && exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o == e, t, rd_data_o, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) mdl_words[k] = '0;
    repeat (2) @(negedge clk_i);
    check(rd_data_o == 0, "R1 rd_data", rd_data_o, 0);
    check(par_rdy_o == 0, "R1 rdy", par_rdy_o, 0);
    check(enc_valid_o == 0, "R1 enc_valid", enc_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6: not-ready read before any parity, no stall
    do_read("R6 empty read");
    do_read("R6 empty read repeat");

    // R2 / R4 / R5: packet A full readout plus wrap
    load_parity(1);
    check(par_rdy_o == 1, "R2 rdy set", par_rdy_o, 1);
    for (int i = 0; i < N; i++) do_read("R4 ordered read");
    do_read("R5 wrap to word0");
    check(par_rdy_o == 1, "R6 read keeps rdy", par_rdy_o, 1);

    // R2: new parity mid-readout reloads and resets pointer
    do_read("R4 read word1");
    load_parity(2);
    do_read("R2 reload word0");
    do_read("R4 next word1");

    // R9: first beat with encoder disabled leaves flag
    first_beat(1'b0);
    check(par_rdy_o == 1, "R9 rdy held", par_rdy_o, 1);
    // R3: first beat with encoder enabled clears flag
    first_beat(1'b1);
    check(par_rdy_o == 0, "R3 rdy cleared", par_rdy_o, 0);
    // R6: reads while not ready return word2 without advancing
    do_read("R6 hold read");
    do_read("R6 hold read again");

    // R8: read data stable without reads
    begin
      logic [W-1:0] snap;
      snap = rd_data_o;
      repeat (3) @(negedge clk_i);
      check(rd_data_o == snap, "R8 stable", rd_data_o, snap);
    end

    // R3 priority: done and first beat together keep flag set
    for (int k = 0; k < N; k++) begin
      mdl_words[k] = W'(16'hc000 + k);
      par_data_i[k*W +: W] = mdl_words[k];
    end
    mdl_ptr = 0; mdl_rdy = 1'b1;
    enc_en_i = 1'b1; data_valid_i = 1'b1; pkt_first_i = 1'b1; par_done_i = 1'b1;
    @(negedge clk_i);
    data_valid_i = 1'b0; pkt_first_i = 1'b0; par_done_i = 1'b0;
    check(par_rdy_o == 1, "R3 set priority", par_rdy_o, 1);
    do_read("R2 priority word0");

    // R7: forwarding gate
    enc_en_i = 1'b0; data_valid_i = 1'b1; data_i = 16'h1234;
    @(negedge clk_i);
    check(enc_valid_o == 0, "R7 disabled no fwd", enc_valid_o, 0);
    enc_en_i = 1'b1; data_i = 16'hbeef;
    @(negedge clk_i);
    data_valid_i = 1'b0;
    check(enc_valid_o == 1, "R7 enabled fwd", enc_valid_o, 1);
    check(enc_data_o == 16'hbeef, "R7 fwd data", enc_data_o, 16'hbeef);

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule